// File: doc/BRIEF.md
# ADC conversion handshake controller

This block sequences one conversion of an 8-bit successive-approximation converter that has an active-low control interface. A one-cycle request on `start_i` makes the controller drive the converter's write strobe low for a fixed number of clock cycles and then release it high. The converter clears its internal approximation state while the strobe is low and starts converting on the rising edge. The controller then waits for the converter's active-low end-of-conversion line. That line is synchronised through two flip-flops before the controller acts on it.

When end of conversion is seen, the controller drives the active-low read enable low for a fixed hold time. On the last cycle of that window it captures the data bus, which the converter drives only while read enable is low. It then releases read enable and presents the sample with a one-cycle valid pulse. If end of conversion does not arrive within a parameterised number of cycles, the controller pulses a timeout flag and returns to idle without reading. Chip select is tied active. A busy output covers the whole sequence, and start requests that arrive while busy are ignored.

The state machine has four states. In `ST_IDLE` the block waits for a request. The transition *start accepted* moves it to `ST_STROBE`, where the write strobe is low. The transition *strobe done* moves it to `ST_WAIT`, where it waits for end of conversion. From there, *conversion seen* moves it to `ST_READ`, where read enable is low, and *timeout* returns it to `ST_IDLE`. From `ST_READ`, *sample captured* returns it to `ST_IDLE`.

Top module: `adc_handshake_ctrl`

## Requirements
- R1: During and after reset, `wr_n_o` and `rd_n_o` are high (1), `cs_n_o` is low (0), and `busy_o`, `valid_o` and `timeout_o` are low (0).
- R2: A high level on `start_i` while idle, sampled at a clock edge, drives `wr_n_o` low from the next cycle for exactly `STROBE_CYC` consecutive cycles, after which `wr_n_o` returns high.
- R3: `busy_o` is high from the first cycle with `wr_n_o` low through the last cycle with `rd_n_o` low. It is low in the cycle in which `valid_o` or `timeout_o` is high.
- R4: While `busy_o` is high, `start_i` has no effect: no second write strobe follows, and exactly one `valid_o` pulse results from the accepted request.
- R5: After `eoc_n_i` falls while waiting, `rd_n_o` goes low in the third cycle, which allows two synchroniser stages and one state register.
- R6: `rd_n_o` stays low for exactly `HOLD_CYC` consecutive cycles, and it is never low at the same time as `wr_n_o`.
- R7: In the cycle after `rd_n_o` returns high, `valid_o` is high for exactly one cycle and `sample_o` equals the value that was on `data_i` during the last cycle with `rd_n_o` low. `sample_o` holds that value until the next capture.
- R8: If `eoc_n_i` stays high for `TIMEOUT_CYC` cycles after `wr_n_o` rises, `timeout_o` is high for one cycle in the cycle after those cycles. In that case `rd_n_o` stays high, `valid_o` stays low, `sample_o` is unchanged, and a new request is accepted afterwards.
- R9: `cs_n_o` is low in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, acted on only when idle |
| eoc_n_i | input | 1 | End of conversion from the converter, active low, asynchronous |
| data_i | input | 8 | Converter data bus, valid only while `rd_n_o` is low |
| cs_n_o | output | 1 | Converter chip select, active low, held low |
| wr_n_o | output | 1 | Converter write strobe, active low |
| rd_n_o | output | 1 | Converter read enable, active low |
| busy_o | output | 1 | High while a conversion sequence is in progress |
| valid_o | output | 1 | One-cycle pulse when `sample_o` holds a new sample |
| sample_o | output | 8 | Last captured sample |
| timeout_o | output | 1 | One-cycle pulse when end of conversion did not arrive in time |

## Verification
Conversions are run with several converter latencies and several sample values. The data bus carries a decoy value whenever read enable is high, so a capture taken outside the read window shows up as the wrong sample. One conversion is run with `start_i` held high during the strobe and wait phases, which tells ignoring a request apart from restarting on it. A run in which the converter never answers separates the timeout path from the normal path. A normal conversion after it shows that the block recovers. The strobe, read and latency lengths are counted cycle by cycle, so an off-by-one in the timer or an extra synchroniser stage is caught.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_READ   = 2'd3
    } hs_state_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
    parameter int  STAGES    = 2,
    parameter bit  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_sample_reg.sv
module adc_sample_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] sample_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sample_o <= '0;
        else if (capture_i) sample_o <= bus_i;
    end

endmodule

// File: rtl/adc_handshake_ctrl.sv
module adc_handshake_ctrl
    import adc_hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STROBE_CYC  = 4,
    parameter int HOLD_CYC    = 3,
    parameter int TIMEOUT_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              eoc_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cs_n_o,
    output logic              wr_n_o,
    output logic              rd_n_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              timeout_o
);

    localparam int MAX_CYC = max3(STROBE_CYC, HOLD_CYC, TIMEOUT_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] STROBE_LD  = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD    = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] TIMEOUT_LD = CNT_W'(TIMEOUT_CYC - 1);

    hs_state_t        state_q, state_d;
    logic             eoc_sync_n;
    logic             eoc_seen;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             capture;
    logic             tout_set;
    logic             valid_q;
    logic             tout_q;

    adc_eoc_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_eoc_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (eoc_n_i),
        .sync_o  (eoc_sync_n)
    );

    assign eoc_seen = ~eoc_sync_n;

    adc_cycle_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .zero_o  (tmr_zero)
    );

    adc_sample_reg #(
        .DATA_W (DATA_W)
    ) i_sample (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .bus_i     (data_i),
        .sample_o  (sample_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= capture;
            tout_q  <= tout_set;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        tout_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = STROBE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TIMEOUT_LD;
                end
            end
            ST_WAIT: begin
                if (eoc_seen) begin
                    state_d  = ST_READ;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end else if (tmr_zero) begin
                    state_d  = ST_IDLE;
                    tout_set = 1'b1;
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_n_o = 1'b1;
        rd_n_o = 1'b1;
        busy_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_STROBE: begin wr_n_o = 1'b0; busy_o = 1'b1; end
            ST_WAIT:   busy_o = 1'b1;
            ST_READ:   begin rd_n_o = 1'b0; busy_o = 1'b1; end
            default:   busy_o = 1'b0;
        endcase
    end

    assign cs_n_o    = 1'b0;
    assign valid_o   = valid_q;
    assign timeout_o = tout_q;

    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o); // R9
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n_o && !rd_n_o)); // R6
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o || !rd_n_o) |-> busy_o); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || timeout_o) |-> !busy_o); // R3
    AST_STROBE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> $past(!busy_o)); // R4
    AST_READ_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> $past(eoc_seen)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7
    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(sample_o)); // R7
    AST_TIMEOUT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && $past(rd_n_o))); // R8

endmodule

// File: tb/test_adc_handshake_ctrl.sv
module test_adc_handshake_ctrl;

    localparam int DW = 8;
    localparam int S  = 4;
    localparam int H  = 3;
    localparam int T  = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          eoc_n = 1'b1;
    logic [DW-1:0] adc_val = '0;
    logic [DW-1:0] bus;
    logic          cs_n, wr_n, rd_n, busy, valid, tout;
    logic [DW-1:0] sample;

    int checks = 0;
    int fails  = 0;
    int overlap_cnt = 0;
    int cs_bad_cnt  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // converter drives its bus only while read enable is low; decoy otherwise
    assign bus = rd_n ? 8'h5A : adc_val;

    adc_handshake_ctrl #(
        .DATA_W(DW), .STROBE_CYC(S), .HOLD_CYC(H), .TIMEOUT_CYC(T), .SYNC_STAGES(2)
    ) i_adc_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .eoc_n_i(eoc_n), .data_i(bus),
        .cs_n_o(cs_n), .wr_n_o(wr_n), .rd_n_o(rd_n), .busy_o(busy), .valid_o(valid),
        .sample_o(sample), .timeout_o(tout)
    );

    always @(negedge clk) begin
        if (rst_n && !wr_n && !rd_n) overlap_cnt++;
        if (cs_n) cs_bad_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 wr_n in reset", wr_n, 1);
        check("R1 rd_n in reset", rd_n, 1);
        check("R1 cs_n in reset", cs_n, 0);
        check("R1 busy in reset", busy, 0);
        check("R1 valid in reset", valid, 0);
        check("R1 timeout in reset", tout, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle wr_n after reset", wr_n, 1);
        check("R1 idle busy after reset", busy, 0);
    endtask

    task automatic t_convert(input logic [DW-1:0] val, input int delay, input bit spam);
        int n;
        int busy_low;
        adc_val = val;
        start_i = 1'b1;
        @(negedge clk);
        check("R2 strobe starts next cycle", wr_n, 0);
        check("R3 busy with strobe", busy, 1);
        if (!spam) start_i = 1'b0;
        n = 0;
        while (!wr_n) begin n++; @(negedge clk); end
        check("R2 strobe length", n, S);
        busy_low = 0;
        for (int i = 0; i < delay; i++) begin
            if (!busy) busy_low++;
            if (!wr_n) busy_low++;
            @(negedge clk);
        end
        check("R3/R4 busy kept, no new strobe while waiting", busy_low, 0);
        start_i = 1'b0;
        eoc_n = 1'b0;
        n = 0;
        while (rd_n && n < 20) begin @(negedge clk); n++; end
        check("R5 eoc to read latency", n, 3);
        eoc_n = 1'b1;
        n = 0;
        while (!rd_n) begin n++; @(negedge clk); end
        check("R6 read window length", n, H);
        check("R7 valid after read", valid, 1);
        check("R7 captured sample", sample, val);
        check("R3 busy low with valid", busy, 0);
        @(negedge clk);
        check("R7 valid single cycle", valid, 0);
        if (spam) begin
            n = 0;
            for (int i = 0; i < 20; i++) begin
                if (!wr_n || valid) n++;
                @(negedge clk);
            end
            check("R4 ignored start makes no second conversion", n, 0);
        end
        repeat (2) @(negedge clk);
        check("R7 sample held", sample, val);
    endtask

    task automatic t_timeout(input logic [DW-1:0] prev);
        int n;
        int rd_seen;
        adc_val = 8'hC3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!wr_n) @(negedge clk);
        n = 0;
        rd_seen = 0;
        while (!tout && n < T + 20) begin
            if (!rd_n) rd_seen++;
            n++;
            @(negedge clk);
        end
        check("R8 timeout after limit", n, T);
        check("R8 no read on timeout", rd_seen, 0);
        check("R8 no valid on timeout", valid, 0);
        check("R8 busy dropped", busy, 0);
        check("R8 sample unchanged", sample, prev);
        @(negedge clk);
        check("R8 timeout single cycle", tout, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        t_reset();
        t_convert(8'hA7, 10, 1'b0);
        t_convert(8'h00, 1, 1'b0);
        t_convert(8'hFF, 300, 1'b1);
        t_timeout(8'hFF);
        t_convert(8'h3C, 40, 1'b0);
        check("R6 read and write never overlap", overlap_cnt, 0);
        check("R9 chip select held low", cs_bad_cnt, 0);
        done = 1'b1;
        summary();
    end

endmodule